// File: doc/BRIEF.md
# Polled Memory-Mapped Device Port

This block is the device side of a small register window on a word-addressed load/store bus. Inside a reserved high address range it offers two channels, each reached through a status word and a data word. The input channel accepts bytes from a keyboard-like source. The output channel passes words to a display-like sink. No memory sits behind the window. Every address in it selects a device register or returns zero.

Software polls bit 0 of a channel's status word until it reads 1. It then loads the input data word or stores to the output data word. That data access clears the channel's ready bit as a side effect. On the device side, a push strobe fills the input latch. The output latch is presented to the sink with a one-cycle valid strobe, and the sink re-arms the channel with an acknowledge pulse. The bus carries at most one access per cycle, either a load or a store. Read data is combinational from the current address. All state changes take effect on the next clock edge.

Top module: `mmio_poll_port`

## Requirements
- R1: An address hits the window when its upper 16 bits equal 0xFFFF (window base 0xFFFF0000); `bus_hit_o` follows this, loads outside the window return 0, and stores outside it change no state.
- R2: A load at window offset 0x0 returns the input ready flag in bit 0 with all other bits zero; a load at offset 0x8 does the same for the output ready flag.
- R3: A push strobe while the input ready flag is 0 sets that flag on the next edge and latches the pushed byte, zero-extended, as the word read at offset 0x4.
- R4: A push strobe while the input ready flag is 1 is dropped: the flag stays set and the word at offset 0x4 keeps its value.
- R5: A load at offset 0x4 returns the latched input word and clears the input ready flag on the next edge; if the flag was 0 and a push arrives in the same cycle, the push wins and the flag is set.
- R6: A store at offset 0xC latches the store data onto `disp_data_o`, clears the output ready flag and raises `disp_valid_o` for exactly the following cycle; a load at 0xC returns the latched word.
- R7: An acknowledge pulse sets the output ready flag on the next edge, except in a cycle with a store at 0xC, which leaves the flag cleared.
- R8: Loads at any other window offset return 0; stores to offsets 0x0, 0x4, 0x8 or any undefined offset change no state.
- R9: Reset clears both ready flags, both data latches and `disp_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_rd_i | input | 1 | Load strobe |
| bus_wr_i | input | 1 | Store strobe |
| bus_wdata_i | input | DATA_W | Store data |
| bus_rdata_o | output | DATA_W | Load data, zero when no load is in the window |
| bus_hit_o | output | 1 | Address lies inside the device window |
| kbd_push_i | input | 1 | Input source offers a byte |
| kbd_data_i | input | IN_W | Byte offered by the input source |
| disp_data_o | output | DATA_W | Word latched for the output sink |
| disp_valid_o | output | 1 | One-cycle strobe after a new output word |
| disp_ack_i | input | 1 | Output sink has consumed the word |

## Verification
On every cycle the assertions check the edge-to-edge channel rules: a push into an empty input latch, a dropped push into a full one, the clear after a data load, the store effects on the output latch and the valid strobe, and the re-arm after an acknowledge. Only the bench scenarios show what software sees through loads. These cover the zero return for undefined and outside addresses, the absence of effect from stores to status and input words, the same-cycle ordering of acknowledge against store and of push against load, and the reset values read back over the bus.

// File: rtl/mmio_poll_pkg.sv
package mmio_poll_pkg;
  localparam int unsigned OFF_IN_CTRL  = 'h0;
  localparam int unsigned OFF_IN_DATA  = 'h4;
  localparam int unsigned OFF_OUT_CTRL = 'h8;
  localparam int unsigned OFF_OUT_DATA = 'hC;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_IN_CTRL,
    SEL_IN_DATA,
    SEL_OUT_CTRL,
    SEL_OUT_DATA
  } reg_sel_e;
endpackage

// File: rtl/mmio_addr_dec.sv
module mmio_addr_dec
  import mmio_poll_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned WIN_BITS = 16,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFFF_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output reg_sel_e          sel_o
);
  localparam int unsigned TAG_W = ADDR_W - WIN_BITS;

  logic [WIN_BITS-1:0] off;

  assign hit_o = (addr_i[ADDR_W-1:WIN_BITS] == BASE[ADDR_W-1:WIN_BITS]);
  assign off   = addr_i[WIN_BITS-1:0];

  always_comb begin
    sel_o = SEL_NONE;
    if (hit_o) begin
      case (off)
        WIN_BITS'(OFF_IN_CTRL):  sel_o = SEL_IN_CTRL;
        WIN_BITS'(OFF_IN_DATA):  sel_o = SEL_IN_DATA;
        WIN_BITS'(OFF_OUT_CTRL): sel_o = SEL_OUT_CTRL;
        WIN_BITS'(OFF_OUT_DATA): sel_o = SEL_OUT_DATA;
        default:                 sel_o = SEL_NONE;
      endcase
    end
  end

  if (TAG_W == 0) begin : g_bad_window
    initial $display("mmio_addr_dec: window covers full address space");
  end
endmodule

// File: rtl/mmio_in_chan.sv
module mmio_in_chan #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IN_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [IN_W-1:0]   push_data_i,
  input  logic              rd_clr_i,
  output logic              rdy_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned PAD_W = DATA_W - IN_W;

  logic              rdy_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q  <= 1'b0;
      data_q <= '0;
    end else if (push_i && !rdy_q) begin
      // push into an empty latch beats a same-cycle load
      rdy_q  <= 1'b1;
      data_q <= {{PAD_W{1'b0}}, push_data_i};
    end else if (rd_clr_i) begin
      rdy_q  <= 1'b0;
    end
  end

  assign rdy_o  = rdy_q;
  assign data_o = data_q;
endmodule

// File: rtl/mmio_out_chan.sv
module mmio_out_chan #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_i,
  output logic              rdy_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  logic              rdy_q;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q   <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (wr_i) begin
      // store beats a same-cycle acknowledge
      rdy_q   <= 1'b0;
      valid_q <= 1'b1;
      data_q  <= wdata_i;
    end else begin
      valid_q <= 1'b0;
      if (ack_i) rdy_q <= 1'b1;
    end
  end

  assign rdy_o   = rdy_q;
  assign valid_o = valid_q;
  assign data_o  = data_q;
endmodule

// File: rtl/mmio_poll_port.sv
module mmio_poll_port
  import mmio_poll_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned IN_W     = 8,
  parameter int unsigned WIN_BITS = 16,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFFF_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_hit_o,
  input  logic              kbd_push_i,
  input  logic [IN_W-1:0]   kbd_data_i,
  output logic [DATA_W-1:0] disp_data_o,
  output logic              disp_valid_o,
  input  logic              disp_ack_i
);
  localparam int unsigned FLAG_PAD = DATA_W - 1;

  reg_sel_e          sel;
  logic              in_rdy;
  logic              out_rdy;
  logic [DATA_W-1:0] in_data;
  logic              in_rd_clr;
  logic              out_wr;

  mmio_addr_dec #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .BASE(BASE)
  ) u_dec (
    .addr_i(bus_addr_i),
    .hit_o (bus_hit_o),
    .sel_o (sel)
  );

  assign in_rd_clr = bus_rd_i && (sel == SEL_IN_DATA);
  assign out_wr    = bus_wr_i && (sel == SEL_OUT_DATA);

  mmio_in_chan #(.DATA_W(DATA_W), .IN_W(IN_W)) u_in (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (kbd_push_i),
    .push_data_i(kbd_data_i),
    .rd_clr_i   (in_rd_clr),
    .rdy_o      (in_rdy),
    .data_o     (in_data)
  );

  mmio_out_chan #(.DATA_W(DATA_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (out_wr),
    .wdata_i(bus_wdata_i),
    .ack_i  (disp_ack_i),
    .rdy_o  (out_rdy),
    .data_o (disp_data_o),
    .valid_o(disp_valid_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_rd_i) begin
      case (sel)
        SEL_IN_CTRL:  bus_rdata_o = {{FLAG_PAD{1'b0}}, in_rdy};
        SEL_IN_DATA:  bus_rdata_o = in_data;
        SEL_OUT_CTRL: bus_rdata_o = {{FLAG_PAD{1'b0}}, out_rdy};
        SEL_OUT_DATA: bus_rdata_o = disp_data_o;
        default:      bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/mmio_poll_chk.sv
module mmio_poll_chk #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned IN_W     = 8,
  parameter int unsigned WIN_BITS = 16,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFFF_0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_rd_i,
  input logic              bus_wr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic              kbd_push_i,
  input logic [IN_W-1:0]   kbd_data_i,
  input logic [DATA_W-1:0] disp_data_o,
  input logic              disp_valid_o,
  input logic              disp_ack_i,
  input logic              in_rdy,
  input logic              out_rdy,
  input logic [DATA_W-1:0] in_data
);
  logic [ADDR_W-1:0] a_in_data;
  logic [ADDR_W-1:0] a_out_data;
  logic              ld_in;
  logic              st_out;

  assign a_in_data  = BASE + ADDR_W'(4);
  assign a_out_data = BASE + ADDR_W'(12);
  assign ld_in      = bus_rd_i && (bus_addr_i == a_in_data);
  assign st_out     = bus_wr_i && (bus_addr_i == a_out_data);

  AST_PUSH_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kbd_push_i && !in_rdy |=> in_rdy && in_data == DATA_W'($past(kbd_data_i))); // R3
  AST_PUSH_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kbd_push_i && in_rdy |=> $stable(in_data)); // R4
  AST_LOAD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_in && in_rdy |=> !in_rdy); // R5
  AST_STORE_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_out |=> disp_valid_o && !out_rdy && disp_data_o == $past(bus_wdata_i)); // R6
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o && !st_out |=> !disp_valid_o); // R6
  AST_ACK_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_ack_i && !st_out |=> out_rdy); // R7
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_out |=> $stable(disp_data_o)); // R8
endmodule

bind mmio_poll_port mmio_poll_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IN_W(IN_W), .WIN_BITS(WIN_BITS), .BASE(BASE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_wr_i    (bus_wr_i),
  .bus_wdata_i (bus_wdata_i),
  .kbd_push_i  (kbd_push_i),
  .kbd_data_i  (kbd_data_i),
  .disp_data_o (disp_data_o),
  .disp_valid_o(disp_valid_o),
  .disp_ack_i  (disp_ack_i),
  .in_rdy      (in_rdy),
  .out_rdy     (out_rdy),
  .in_data     (in_data)
);

// File: tb/sim_mmio_poll_port.sv
`timescale 1ns/1ps
module sim_mmio_poll_port;
  localparam logic [31:0] WB = 32'hFFFF_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] bus_addr_i = '0;
  logic        bus_rd_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        bus_hit_o;
  logic        kbd_push_i = 1'b0;
  logic [7:0]  kbd_data_i = '0;
  logic [31:0] disp_data_o;
  logic        disp_valid_o;
  logic        disp_ack_i = 1'b0;

  int checks = 0;
  int errors = 0;

  logic        m_in_rdy, m_out_rdy, m_valid;
  logic [31:0] m_in_data, m_out_data;

  always #2.5 clk_i = ~clk_i;

  mmio_poll_port u0 (.*);

  function automatic logic [31:0] exp_read(input logic [31:0] a);
    if (a[31:16] != 16'hFFFF) return 32'h0;
    case (a[15:0])
      16'h0:   return {31'h0, m_in_rdy};
      16'h4:   return m_in_data;
      16'h8:   return {31'h0, m_out_rdy};
      16'hC:   return m_out_data;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one bus cycle: drive after negedge, check load data, model the edge, check outputs
  task automatic step(input logic push, input logic [7:0] kd, input logic ack,
                      input logic rd, input logic wr, input logic [31:0] a,
                      input logic [31:0] wd, input string req);
    bus_addr_i = a; bus_rd_i = rd; bus_wr_i = wr; bus_wdata_i = wd;
    kbd_push_i = push; kbd_data_i = kd; disp_ack_i = ack;
    #1;
    chk({31'h0, bus_hit_o}, {31'h0, a[31:16] == 16'hFFFF}, {req, " R1 hit"});
    if (rd) chk(bus_rdata_o, exp_read(a), req);
    @(posedge clk_i);
    if (push && !m_in_rdy) begin
      m_in_rdy = 1'b1; m_in_data = {24'h0, kd};
    end else if (rd && a == WB + 32'h4) m_in_rdy = 1'b0;
    if (wr && a == WB + 32'hC) begin
      m_out_data = wd; m_out_rdy = 1'b0; m_valid = 1'b1;
    end else begin
      m_valid = 1'b0;
      if (ack) m_out_rdy = 1'b1;
    end
    @(negedge clk_i);
    chk({31'h0, disp_valid_o}, {31'h0, m_valid}, {req, " R6 valid"});
    chk(disp_data_o, m_out_data, {req, " R6 data"});
    bus_rd_i = 1'b0; bus_wr_i = 1'b0; kbd_push_i = 1'b0; disp_ack_i = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, input string req);
    step(1'b0, 8'h0, 1'b0, 1'b1, 1'b0, a, 32'h0, req);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input string req);
    step(1'b0, 8'h0, 1'b0, 1'b0, 1'b1, a, d, req);
  endtask

  function automatic logic [31:0] pick_addr(input int k);
    case (k)
      0: return WB;
      1: return WB + 32'h4;
      2: return WB + 32'h8;
      3: return WB + 32'hC;
      4: return WB + 32'h10;
      5: return WB + 32'h6;
      6: return 32'h0000_0004;
      default: return 32'hFFFE_000C;
    endcase
  endfunction

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_in_rdy = 0; m_out_rdy = 0; m_valid = 0; m_in_data = 0; m_out_data = 0;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9 reset state
    chk({31'h0, disp_valid_o}, 32'h0, "R9 valid");
    chk(disp_data_o, 32'h0, "R9 disp data");
    rd(WB, "R9 in ctrl"); rd(WB + 32'h4, "R9 in data");
    rd(WB + 32'h8, "R9 out ctrl"); rd(WB + 32'hC, "R9 out data");

    // R3 push, R2 poll, R4 dropped push, R5 clearing load
    step(1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, WB, 32'h0, "R3 push");
    rd(WB, "R2 in ctrl set");
    step(1'b1, 8'h3C, 1'b0, 1'b0, 1'b0, WB, 32'h0, "R4 push while full");
    rd(WB + 32'h4, "R4 R5 load keeps first byte");
    rd(WB, "R5 ready cleared");
    // R5 push wins over a same-cycle load of an empty latch
    step(1'b1, 8'h77, 1'b0, 1'b1, 1'b0, WB + 32'h4, 32'h0, "R5 push with load");
    rd(WB, "R5 push won");
    rd(WB + 32'h4, "R5 load new byte");

    // R8 ignored stores, undefined offsets
    wr(WB, 32'hFFFF_FFFF, "R8 store in ctrl");
    wr(WB + 32'h4, 32'h1234_5678, "R8 store in data");
    wr(WB + 32'h8, 32'h1, "R8 store out ctrl");
    wr(WB + 32'h20, 32'hDEAD_BEEF, "R8 store undefined");
    rd(WB, "R8 in ctrl unchanged"); rd(WB + 32'h4, "R8 in data unchanged");
    rd(WB + 32'h8, "R8 out ctrl unchanged"); rd(WB + 32'h10, "R8 undefined reads zero");
    // R1 outside window
    wr(32'h0000_000C, 32'hCAFE_0001, "R1 store outside");
    rd(32'h0000_000C, "R1 load outside");
    rd(WB + 32'hC, "R1 out data unchanged");

    // R7 ack arms, R6 store clears, same-cycle order
    step(1'b0, 8'h0, 1'b1, 1'b0, 1'b0, WB, 32'h0, "R7 ack");
    rd(WB + 32'h8, "R7 out ready set");
    wr(WB + 32'hC, 32'h0BAD_F00D, "R6 store out data");
    rd(WB + 32'h8, "R6 out ready cleared");
    rd(WB + 32'hC, "R6 load out data");
    step(1'b0, 8'h0, 1'b1, 1'b0, 1'b1, WB + 32'hC, 32'h5555_AAAA, "R7 ack with store");
    rd(WB + 32'h8, "R7 store wins");

    // random traffic
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom % 3;
      step(($urandom % 3) == 0, 8'($urandom), ($urandom % 4) == 0,
           op == 1, op == 2, pick_addr($urandom % 8), $urandom, "random");
    end

    // R9 reset mid-run
    rst_ni = 1'b0;
    #1;
    m_in_rdy = 0; m_out_rdy = 0; m_valid = 0; m_in_data = 0; m_out_data = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(WB + 32'h4, "R9 in data after reset");
    rd(WB + 32'h8, "R9 out ctrl after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule